// File: doc/BRIEF.md
# Stereo Frame Delay for Serial Audio

This block is placed in the data line of a two-channel serial audio link (standard I2S, left-justified or right-justified framing) and delays the audio by a whole number of stereo frames. It runs on the link's own bit clock and word clock, and it changes neither. Downstream logic keeps using the original clocks and takes only the data line from this block.

Each channel slot is 32 bit clocks long. The block treats the slot as an opaque 32-bit word. It shifts the word in and writes it into a circular slot memory that holds `2^FRAME_AW` frames. It reads back the slot of the same channel that was stored a chosen number of frames earlier and shifts that slot out in the same bit positions, relative to the word clock, that the input used. The delay is set through a value port and a one-cycle load strobe. A new delay takes effect at a frame start. Any slot whose source frame has not been stored since reset or since the last delay change is played as silence.

Top module: `stereo_frame_delay`

## Requirements
- R1: `sdin` and `lrclk` are sampled on rising `bclk` edges. `sdout` changes only on falling `bclk` edges.
- R2: A slot starts at the rising edge where the sampled `lrclk` differs from its previous sample. The data bit taken at that edge is slot bit 0, which is stored as the word's MSB. Output bit j of a slot is driven so that a receiver sampling on rising edges sees it at the same edge as input bit j of the concurrent input slot.
- R3: With `lr_invert` = 0, `lrclk` high marks the left channel. With `lr_invert` = 1, `lrclk` low marks the left channel. A frame is a left slot followed by a right slot.
- R4: With active delay D, the output slot during input frame g, channel c carries the input slot of frame g−1−D, channel c.
- R5: A requested delay above `2^FRAME_AW − 1` is clamped to `2^FRAME_AW − 1`.
- R6: After reset, let frame 0 be the first frame whose left slot begins with a word-clock edge. Output frames g < 1 + D are all zeros.
- R7: A `dly_load` pulse captures `dly_value` at its rising edge. If the pulse falls in a left slot of frame f, the new delay D governs output from frame f+1 onward, and output frames f+1 to f+D are all zeros.
- R8: During reset, and until frame 0 begins, `sdout` is 0.
- R9: All 32 bits of every slot are reproduced unchanged, whatever their content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic runs from it |
| rst | input | 1 | Synchronous active-high reset |
| lrclk | input | 1 | Word clock marking the channel of each slot |
| sdin | input | 1 | Serial input data |
| lr_invert | input | 1 | 1 means `lrclk` low marks the left channel |
| dly_value | input | DLY_W | Requested delay in frames |
| dly_load | input | 1 | One-cycle strobe that captures `dly_value` |
| sdout | output | 1 | Delayed serial output data, driven on falling edges |

## Verification
The bench sweeps every delay of an 8-frame memory and compares each whole output slot with the frame predicted arithmetically. A design with an off-by-one in read addressing or in pipeline latency fails on every non-silent slot. Silent frames are counted after reset and after every delay change; a fill check with the wrong threshold either plays stale memory or drops one real frame. A request of 20 frames must behave as 7, so a missing clamp would wrap the read pointer. A rerun with inverted word-clock sense catches a swapped channel order. Sampling `sdout` on both sides of each rising edge exposes an output driven from the wrong clock edge.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  // Word-clock event seen at one rising bit-clock edge
  typedef struct packed {
    logic hit;        // sampled word clock changed: a new slot starts here
    logic done_left;  // the slot that just ended belonged to the left channel
    logic new_left;   // the slot that starts now belongs to the left channel
  } ws_evt_t;
endpackage

// File: rtl/sfd_slot_rx.sv
module sfd_slot_rx #(
  parameter int SLOT_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ws,
  input  logic               sd,
  input  logic               inv,
  output sfd_pkg::ws_evt_t   evt,
  output logic [CNT_W-1:0]   cnt,
  output logic               cur_left,
  output logic [SLOT_W-1:0]  word
);
  logic              ws_q;
  logic [SLOT_W-1:0] shreg;

  always_comb begin
    evt.hit       = ws ^ ws_q;
    evt.done_left = ws_q ^ inv;
    evt.new_left  = ws ^ inv;
  end

  // Before the shift at a slot start, shreg still holds the finished slot.
  assign word = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q     <= ws;
      shreg    <= '0;
      cnt      <= '0;
      cur_left <= 1'b0;
    end else begin
      ws_q  <= ws;
      shreg <= {shreg[SLOT_W-2:0], sd};
      if (evt.hit) begin
        cnt      <= '0;
        cur_left <= ws ^ inv;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R2: without a word-clock edge the bit index advances by exactly one
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (rst)
    !evt.hit |=> cnt == ($past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/sfd_ring_ram.sv
module sfd_ring_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfd_ring_ctrl.sv
module sfd_ring_ctrl #(
  parameter int SLOT_W   = 32,
  parameter int CNT_W    = 5,
  parameter int FRAME_AW = 10,
  parameter int DLY_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  sfd_pkg::ws_evt_t    evt,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                cur_left,
  input  logic [DLY_W-1:0]    dly_in,
  input  logic                dly_load,
  output logic                we,
  output logic [FRAME_AW:0]   waddr,
  output logic                re,
  output logic [FRAME_AW:0]   raddr,
  output logic                rd_ok
);
  localparam int DEPTH = 1 << FRAME_AW;
  localparam logic [CNT_W-1:0] ISSUE = CNT_W'(SLOT_W - 3);
  localparam logic [FRAME_AW-1:0] DMAX = FRAME_AW'(DEPTH - 1);
  localparam logic [FRAME_AW:0]   FULL = (FRAME_AW+1)'(DEPTH);

  logic                locked;
  logic [FRAME_AW-1:0] wr_frame;
  logic [FRAME_AW:0]   fill;
  logic [FRAME_AW-1:0] dly_cur, dly_pend, dly_clamped, eff_dly, rd_frame;
  logic                pend, issue, apply, next_right, frame_done, ok;
  logic [FRAME_AW:0]   fill_eff, need;

  always_comb begin
    dly_clamped = (dly_in > DLY_W'(DEPTH - 1)) ? DMAX : dly_in[FRAME_AW-1:0];
    next_right  = cur_left;
    issue       = locked && (cnt == ISSUE) && !evt.hit;
    apply       = issue && !cur_left && pend;
    eff_dly     = apply ? dly_pend : dly_cur;
    fill_eff    = apply ? '0 : fill;
    rd_frame    = wr_frame - eff_dly - FRAME_AW'(next_right);
    need        = {1'b0, eff_dly} + (FRAME_AW+1)'(next_right);
    ok          = fill_eff >= need;
    frame_done  = evt.hit && locked && !evt.done_left;
    we          = evt.hit && locked;
    waddr       = {wr_frame, !evt.done_left};
    re          = issue;
    raddr       = {rd_frame, next_right};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      wr_frame <= '0;
      fill     <= '0;
      dly_cur  <= '0;
      dly_pend <= '0;
      pend     <= 1'b0;
      rd_ok    <= 1'b0;
    end else begin
      if (evt.hit && evt.new_left) locked <= 1'b1;
      if (frame_done) wr_frame <= wr_frame + FRAME_AW'(1);
      if (apply) fill <= '0;
      else if (frame_done && fill != FULL) fill <= fill + (FRAME_AW+1)'(1);
      if (dly_load) begin
        dly_pend <= dly_clamped;
        pend     <= 1'b1;
      end else if (apply) begin
        pend <= 1'b0;
      end
      if (apply) dly_cur <= dly_pend;
      if (issue) rd_ok <= ok;
    end
  end

  // R7: the active delay changes only at the read that feeds a left slot
  a_r7_apply_left_only: assert property (@(posedge clk) disable iff (rst)
    (dly_cur != $past(dly_cur)) |-> (!$past(cur_left) && $past(cnt) == ISSUE));

  // R6: the count of stored frames never passes the memory depth
  a_r6_fill_bounded: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL);
endmodule

// File: rtl/sfd_slot_tx.sv
module sfd_slot_tx #(
  parameter int SLOT_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              slot_hit,
  input  logic [SLOT_W-1:0] rdata,
  input  logic              rd_ok,
  output logic              sdout
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SLOT_W - 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_W - 1);

  logic [SLOT_W-1:0] tx;
  logic              early, load;

  always_comb begin
    early = slot_hit && (cnt != LAST);
    load  = (cnt == LOAD) && !slot_hit;
  end

  // Loaded one bit before the predicted boundary so bit 0 is on the line in time
  always_ff @(posedge clk) begin
    if (rst)        tx <= '0;
    else if (early) tx <= '0;
    else if (load)  tx <= rd_ok ? rdata : '0;
    else            tx <= {tx[SLOT_W-2:0], 1'b0};
  end

  always_ff @(negedge clk) begin
    if (rst) sdout <= 1'b0;
    else     sdout <= tx[SLOT_W-1];
  end

  // R6: a slot without a stored source frame is loaded as silence
  a_r6_blank_load: assert property (@(posedge clk) disable iff (rst)
    (load && !early && !rd_ok) |=> tx == '0);
endmodule

// File: rtl/stereo_frame_delay.sv
module stereo_frame_delay #(
  parameter int SLOT_W   = 32,
  parameter int FRAME_AW = 10,
  parameter int DLY_W    = 12
) (
  input  logic             bclk,
  input  logic             rst,
  input  logic             lrclk,
  input  logic             sdin,
  input  logic             lr_invert,
  input  logic [DLY_W-1:0] dly_value,
  input  logic             dly_load,
  output logic             sdout
);
  localparam int CNT_W = $clog2(SLOT_W);
  localparam int MAW   = FRAME_AW + 1;

  sfd_pkg::ws_evt_t  evt;
  logic [CNT_W-1:0]  cnt;
  logic              cur_left, we, re, rd_ok;
  logic [SLOT_W-1:0] word, rdata;
  logic [MAW-1:0]    waddr, raddr;

  sfd_slot_rx #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_rx (
    .clk(bclk), .rst(rst), .ws(lrclk), .sd(sdin), .inv(lr_invert),
    .evt(evt), .cnt(cnt), .cur_left(cur_left), .word(word));

  sfd_ring_ctrl #(.SLOT_W(SLOT_W), .CNT_W(CNT_W), .FRAME_AW(FRAME_AW), .DLY_W(DLY_W)) u_ctrl (
    .clk(bclk), .rst(rst), .evt(evt), .cnt(cnt), .cur_left(cur_left),
    .dly_in(dly_value), .dly_load(dly_load), .we(we), .waddr(waddr),
    .re(re), .raddr(raddr), .rd_ok(rd_ok));

  sfd_ring_ram #(.AW(MAW), .DW(SLOT_W)) u_ram (
    .clk(bclk), .we(we), .waddr(waddr), .wdata(word),
    .re(re), .raddr(raddr), .rdata(rdata));

  sfd_slot_tx #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_tx (
    .clk(bclk), .rst(rst), .cnt(cnt), .slot_hit(evt.hit),
    .rdata(rdata), .rd_ok(rd_ok), .sdout(sdout));
endmodule

// File: tb/tb_stereo_frame_delay.sv
module tb_stereo_frame_delay;
  localparam int CLK_PERIOD = 10;
  localparam int FAW   = 3;
  localparam int DW    = 5;
  localparam int DEPTH = 1 << FAW;

  logic bclk = 1'b0;
  logic rst = 1'b1;
  logic lrclk = 1'b0;
  logic sdin = 1'b0;
  logic lr_invert = 1'b0;
  logic [DW-1:0] dly_value = '0;
  logic dly_load = 1'b0;
  logic sdout;

  int checks = 0;
  int fails = 0;
  int g, dcur, a_frm, pnew;
  bit pd, fresh;
  string tag;

  stereo_frame_delay #(.SLOT_W(32), .FRAME_AW(FAW), .DLY_W(DW)) dut (
    .bclk(bclk), .rst(rst), .lrclk(lrclk), .sdin(sdin), .lr_invert(lr_invert),
    .dly_value(dly_value), .dly_load(dly_load), .sdout(sdout));

  always #(CLK_PERIOD/2) bclk = ~bclk;

  // R9: every bit of the word varies with frame and channel, LSBs included
  function automatic logic [31:0] gen(input int f, input int ch);
    logic [31:0] v;
    v = {8'h5A ^ f[7:0], (ch != 0) ? 8'hC3 : 8'h3C, f[15:0] ^ 16'h8001};
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s frame=%0d got=%h exp=%h", req, g, got, exp);
    end
  endtask

  task automatic do_reset(input bit inv);
    rst = 1'b1;
    lr_invert = inv;
    lrclk = inv;
    dly_load = 1'b0;
    repeat (4) @(negedge bclk);
    #1 check(sdout === 1'b0, "R8", {31'b0, sdout}, 32'h0);
    rst = 1'b0;
    begin
      bit bad = 1'b0;
      // idle with constant right-channel level: output must stay silent
      for (int j = 0; j < 40; j++) begin
        @(negedge bclk);
        lrclk = inv;
        sdin = j[0];
        @(posedge bclk);
        #1 if (sdout !== 1'b0) bad = 1'b1;
      end
      check(!bad, "R8", {31'b0, bad}, 32'h0);
    end
    g = 0; dcur = 0; a_frm = 1; pd = 0; fresh = 1;
  endtask

  // Sends one frame; optionally strobes a new delay at bit lb of the left slot
  task automatic send_frame(input int lb, input int nv);
    if (pd) begin
      dcur = pnew; a_frm = g; pd = 0; fresh = 0;
    end
    for (int ch = 0; ch < 2; ch++) begin
      logic [31:0] w, rxw, exp;
      bit stable_bad;
      w = gen(g, ch);
      rxw = '0;
      stable_bad = 0;
      exp = (g >= a_frm + dcur) ? gen(g - 1 - dcur, ch) : 32'h0;
      for (int j = 0; j < 32; j++) begin
        logic sa;
        @(negedge bclk);
        lrclk = (ch == 0) ? ~lr_invert : lr_invert;  // R3
        sdin = w[31-j];                               // R2: MSB first
        if (ch == 0 && j == lb) begin
          dly_value = DW'(nv);
          dly_load = 1'b1;
        end else begin
          dly_load = 1'b0;
        end
        #1 sa = sdout;
        @(posedge bclk);
        #1 if (sdout !== sa) stable_bad = 1;
        rxw = {rxw[30:0], sdout};
      end
      if (ch == 0 && lb >= 0) begin
        pd = 1;
        pnew = (nv > DEPTH - 1) ? DEPTH - 1 : nv;     // R5 clamp model
      end
      check(!stable_bad, "R1", {31'b0, stable_bad}, 32'h0);
      if (exp == 32'h0) check(rxw === exp, fresh ? "R6" : "R7", rxw, exp);
      else check(rxw === exp, tag, rxw, exp);        // R4 / R9 data path
    end
    g++;
  endtask

  initial begin
    do_reset(1'b0);
    // R4: sweep every delay 0..DEPTH-1
    for (int d = 0; d < DEPTH; d++) begin
      tag = "R4";
      send_frame(4, d);
      for (int k = 0; k < d + 2; k++) send_frame(-1, 0);
    end
    // R5: request beyond depth behaves as DEPTH-1
    tag = "R5";
    send_frame(9, 20);
    for (int k = 0; k < DEPTH + 1; k++) send_frame(-1, 0);
    // R3: inverted word-clock sense, fresh reset
    do_reset(1'b1);
    tag = "R3";
    send_frame(2, 2);
    for (int k = 0; k < 6; k++) send_frame(-1, 0);
    // R9: zero delay again after a long delay, data must be exact
    tag = "R9";
    send_frame(30, 0);
    for (int k = 0; k < 3; k++) send_frame(-1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired at frame=%0d", g);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule